// File: doc/BRIEF.md
# Immediate-Offset Word Load Unit

This unit accepts one fetched word-load instruction whose offset is an immediate and carries it out. The instruction can be in the fixed 32-bit encoding or in one of the compact encodings: two 16-bit forms and two 32-bit forms. The unit decodes the base index, the destination index, the immediate and the addressing flags. It reads the base value from an external register file through a combinational read port. It then forms the offset address and the access address and issues one word read on a valid/ready request port. When the response arrives, it offers the base writeback and the destination write on two independent write ports.

Encodings that belong to other instructions are reported instead of executed. These are the PC-relative literal form, the unprivileged form, undefined flag combinations and patterns that are not this load at all. The unit also reports a writeback-equals-destination hazard. A load into the program counter produces a branch when the access address is word aligned and raises an error flag when it is not. For the wide compact forms, a PC destination inside a conditional group is refused unless it is the last instruction of that group.

Top module: `ldx_unit`

## Requirements
- R1: With `in_compact`=0, a word is this load when bits 31:28 differ from 1111, bits 27:25 are 010, bit 22 is 0 and bit 20 is 1. Base is bits 19:16, destination is bits 15:12 and the zero-extended immediate is bits 11:0. Pre-index equals bit 24, add equals bit 23, and writeback is set when bit 24 is 0 or bit 21 is 1.
- R2: With `in_compact`=1, a 16-bit form sits in bits 31:16. Prefix 01101 takes imm5 in bits 26:22, base in 21:19 and destination in 18:16. Prefix 10011 takes destination in bits 26:24 and imm8 in 23:16, with register 13 as base. Both forms scale the immediate by 4 and use pre-index, add, and no writeback.
- R3: With `in_compact`=1, bits 31:20 = F8D select a wide form with imm12 in 11:0, using pre-index, add and no writeback. Bits 31:20 = F85 with bit 11 set select an imm8 form in 7:0, with pre-index, add and writeback taken from bits 10, 9 and 8. In both wide forms, base is bits 19:16 and destination is bits 15:12.
- R4: The offset address is base+imm when add is set and base-imm otherwise. The request address is the offset address when pre-index is set and the unmodified base otherwise. When writeback is set, `wb_we` writes the offset address to the base index.
- R5: A refused instruction issues no request and performs no write or branch. One cycle after acceptance it raises `done` with a `done_kind` code: 1 for a literal form (base field 1111 in the fixed or a wide form), 2 for an unprivileged form (fixed with P=0,W=1; imm8 form with P=1,U=1,W=0), 3 for undefined (imm8 form with P=0,W=0), and 4 for any foreign pattern. An executed load reports 0.
- R6: When writeback is set and base equals destination, `hazard` rises with `done`, and the load and both writes still take place.
- R7: When the destination is 15 and request address bits 1:0 are 00, the loaded word appears on `br_target` with `br_valid` and no destination write. When bits 1:0 are not 00, `align_err` rises and there is neither a branch nor a destination write.
- R8: A wide compact form with destination 15, `in_it_inside`=1 and `in_it_last`=0 is refused with code 5. When it is the last instruction of its group, it executes.
- R9: `req_valid` stays high with a stable address until `req_ready`. `busy` is high and `in_ready` is low from acceptance until the response cycle. Writes and `done` occur in the cycle where `rsp_valid` is seen.
- R10: After reset, `in_ready` is high and `busy`, `req_valid`, `done` and all write and branch strobes are low.
- R11: A post-indexed add from base 13 with immediate 4 returns the word at the old base and writes back the old base plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, instruction accepted when valid |
| in_instr | input | 32 | Instruction bits (compact 16-bit forms in 31:16) |
| in_compact | input | 1 | 1 selects the compact encoding set |
| in_it_inside | input | 1 | Instruction lies in a conditional group |
| in_it_last | input | 1 | Instruction is the last of its group |
| base_ridx | output | 4 | Base register read index |
| base_rdata | input | 32 | Base register value for `base_ridx` |
| req_valid | output | 1 | Memory read request |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 32 | Word read address |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 32 | Read data |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | Instruction completes this cycle |
| done_kind | output | 3 | Completion code (R5, R8) |
| hazard | output | 1 | Writeback index equals destination |
| align_err | output | 1 | PC load from unaligned address |
| wb_we | output | 1 | Base writeback strobe |
| wb_idx | output | 4 | Base writeback index |
| wb_data | output | 32 | Base writeback value |
| dst_we | output | 1 | Destination write strobe |
| dst_idx | output | 4 | Destination index |
| dst_data | output | 32 | Destination value |
| br_valid | output | 1 | Branch to loaded word |
| br_target | output | 32 | Branch target |

## Verification
The bench builds the unit with its default parameters: 32-bit data, 4-bit register indices, register 13 as implied stack base and register 15 as program counter. With the stack base at 13, the SP-relative short form and the stack-pop pattern run through real base values. With 15 as program counter, literal refusal, the branch path, the misalignment error and the conditional-group refusal can all be reached by choosing destination and base indices. The bench's memory model varies the ready delay and the response latency, so the request-hold and busy rules are exercised with stalls on both phases.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
  parameter int unsigned XW  = 32;
  parameter int unsigned RIW = 4;

  typedef enum logic [2:0] {
    K_DONE    = 3'd0,
    K_LITERAL = 3'd1,
    K_UNPRIV  = 3'd2,
    K_UNDEF   = 3'd3,
    K_FOREIGN = 3'd4,
    K_ITPC    = 3'd5
  } kind_e;

  typedef struct packed {
    logic [RIW-1:0] rn;
    logic [RIW-1:0] rt;
    logic [XW-1:0]  imm;
    logic           index;
    logic           add;
    logic           wback;
    kind_e          kind;
  } dec_t;
endpackage

// File: rtl/ldx_rst_sync.sv
module ldx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ldx_decode.sv
module ldx_decode
  import ldx_pkg::*;
#(
  parameter int unsigned SP_IDX = 13,
  parameter int unsigned PC_IDX = 15
) (
  input  logic [XW-1:0] instr,
  input  logic          compact,
  input  logic          it_inside,
  input  logic          it_last,
  output dec_t          dec
);
  localparam logic [RIW-1:0] SP_R = RIW'(SP_IDX);
  localparam logic [RIW-1:0] PC_R = RIW'(PC_IDX);

  logic pc_in_group;
  assign pc_in_group = it_inside && !it_last;

  always_comb begin
    dec      = '0;
    dec.kind = K_FOREIGN;
    if (!compact) begin
      if (instr[31:28] != 4'hF && instr[27:25] == 3'b010 && !instr[22] && instr[20]) begin
        dec.rn    = instr[19:16];
        dec.rt    = instr[15:12];
        dec.imm   = XW'(instr[11:0]);
        dec.index = instr[24];
        dec.add   = instr[23];
        dec.wback = !instr[24] || instr[21];
        if (dec.rn == PC_R)                dec.kind = K_LITERAL;
        else if (!instr[24] && instr[21])  dec.kind = K_UNPRIV;
        else                               dec.kind = K_DONE;
      end
    end else if (instr[31:27] == 5'b01101) begin
      dec.rn    = RIW'(instr[21:19]);
      dec.rt    = RIW'(instr[18:16]);
      dec.imm   = XW'({instr[26:22], 2'b00});
      dec.index = 1'b1;
      dec.add   = 1'b1;
      dec.kind  = K_DONE;
    end else if (instr[31:27] == 5'b10011) begin
      dec.rn    = SP_R;
      dec.rt    = RIW'(instr[26:24]);
      dec.imm   = XW'({instr[23:16], 2'b00});
      dec.index = 1'b1;
      dec.add   = 1'b1;
      dec.kind  = K_DONE;
    end else if (instr[31:20] == 12'hF8D) begin
      dec.rn    = instr[19:16];
      dec.rt    = instr[15:12];
      dec.imm   = XW'(instr[11:0]);
      dec.index = 1'b1;
      dec.add   = 1'b1;
      if (dec.rn == PC_R)                          dec.kind = K_LITERAL;
      else if (dec.rt == PC_R && pc_in_group)      dec.kind = K_ITPC;
      else                                         dec.kind = K_DONE;
    end else if (instr[31:20] == 12'hF85 && instr[11]) begin
      dec.rn    = instr[19:16];
      dec.rt    = instr[15:12];
      dec.imm   = XW'(instr[7:0]);
      dec.index = instr[10];
      dec.add   = instr[9];
      dec.wback = instr[8];
      if (dec.rn == PC_R)                              dec.kind = K_LITERAL;
      else if (instr[10] && instr[9] && !instr[8])     dec.kind = K_UNPRIV;
      else if (!instr[10] && !instr[8])                dec.kind = K_UNDEF;
      else if (dec.rt == PC_R && pc_in_group)          dec.kind = K_ITPC;
      else                                             dec.kind = K_DONE;
    end
  end
endmodule

// File: rtl/ldx_agen.sv
module ldx_agen
  import ldx_pkg::*;
(
  input  logic [XW-1:0] base,
  input  logic [XW-1:0] imm,
  input  logic          add,
  input  logic          index,
  output logic [XW-1:0] offs_addr,
  output logic [XW-1:0] mem_addr
);
  always_comb begin
    offs_addr = add ? (base + imm) : (base - imm);
    mem_addr  = index ? offs_addr : base;
  end
endmodule

// File: rtl/ldx_seq.sv
module ldx_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_n,
  input  logic accept,
  input  logic refuse,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic idle,
  output logic req_phase,
  output logic rsp_fire,
  output logic fin_phase
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_FIN} st_e;
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (accept)    st_d = refuse ? S_FIN : S_REQ;
      S_REQ:  if (req_ready) st_d = S_WAIT;
      S_WAIT: if (rsp_valid) st_d = S_IDLE;
      S_FIN:                 st_d = S_IDLE;
      default:               st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  assign idle      = (st_q == S_IDLE);
  assign req_phase = (st_q == S_REQ);
  assign rsp_fire  = (st_q == S_WAIT) && rsp_valid;
  assign fin_phase = (st_q == S_FIN);

  // R9
  completion_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire || fin_phase) |=> idle);

  // R5
  refuse_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && refuse && idle) |=> fin_phase && !req_phase);
endmodule

// File: rtl/ldx_unit.sv
module ldx_unit
  import ldx_pkg::*;
#(
  parameter int unsigned SP_IDX = 13,
  parameter int unsigned PC_IDX = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [XW-1:0]  in_instr,
  input  logic           in_compact,
  input  logic           in_it_inside,
  input  logic           in_it_last,
  output logic [RIW-1:0] base_ridx,
  input  logic [XW-1:0]  base_rdata,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [XW-1:0]  req_addr,
  input  logic           rsp_valid,
  input  logic [XW-1:0]  rsp_data,
  output logic           busy,
  output logic           done,
  output logic [2:0]     done_kind,
  output logic           hazard,
  output logic           align_err,
  output logic           wb_we,
  output logic [RIW-1:0] wb_idx,
  output logic [XW-1:0]  wb_data,
  output logic           dst_we,
  output logic [RIW-1:0] dst_idx,
  output logic [XW-1:0]  dst_data,
  output logic           br_valid,
  output logic [XW-1:0]  br_target
);
  localparam logic [RIW-1:0] PC_R = RIW'(PC_IDX);

  logic          srst_n;
  dec_t          dec;
  logic [XW-1:0] offs_addr, mem_addr;
  logic          idle, req_phase, rsp_fire, fin_phase, accept;

  ldx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  ldx_decode #(.SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_dec (
    .instr(in_instr), .compact(in_compact),
    .it_inside(in_it_inside), .it_last(in_it_last), .dec(dec)
  );

  ldx_agen u_agen (
    .base(base_rdata), .imm(dec.imm), .add(dec.add), .index(dec.index),
    .offs_addr(offs_addr), .mem_addr(mem_addr)
  );

  assign accept = in_valid && idle;

  ldx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n),
    .accept(accept), .refuse(dec.kind != K_DONE),
    .req_ready(req_ready), .rsp_valid(rsp_valid),
    .idle(idle), .req_phase(req_phase), .rsp_fire(rsp_fire), .fin_phase(fin_phase)
  );

  // captured instruction context
  logic [XW-1:0]  addr_q, offs_q, addr_d, offs_d;
  logic [RIW-1:0] rn_q, rt_q, rn_d, rt_d;
  logic           wback_q, wback_d;
  kind_e          kind_q, kind_d;

  always_comb begin
    addr_d  = addr_q;
    offs_d  = offs_q;
    rn_d    = rn_q;
    rt_d    = rt_q;
    wback_d = wback_q;
    kind_d  = kind_q;
    if (accept) begin
      addr_d  = mem_addr;
      offs_d  = offs_addr;
      rn_d    = dec.rn;
      rt_d    = dec.rt;
      wback_d = dec.wback;
      kind_d  = dec.kind;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q  <= '0;
      offs_q  <= '0;
      rn_q    <= '0;
      rt_q    <= '0;
      wback_q <= 1'b0;
      kind_q  <= K_DONE;
    end else if (accept) begin
      addr_q  <= addr_d;
      offs_q  <= offs_d;
      rn_q    <= rn_d;
      rt_q    <= rt_d;
      wback_q <= wback_d;
      kind_q  <= kind_d;
    end
  end

  logic pc_dst, aligned;
  assign pc_dst  = (rt_q == PC_R);
  assign aligned = (addr_q[1:0] == 2'b00);

  assign in_ready  = idle;
  assign busy      = !idle;
  assign base_ridx = dec.rn;
  assign req_valid = req_phase;
  assign req_addr  = addr_q;
  assign done      = rsp_fire || fin_phase;
  assign done_kind = kind_q;
  assign hazard    = rsp_fire && wback_q && (rn_q == rt_q);
  assign align_err = rsp_fire && pc_dst && !aligned;
  assign wb_we     = rsp_fire && wback_q;
  assign wb_idx    = rn_q;
  assign wb_data   = offs_q;
  assign dst_we    = rsp_fire && !pc_dst;
  assign dst_idx   = rt_q;
  assign dst_data  = rsp_data;
  assign br_valid  = rsp_fire && pc_dst && aligned;
  assign br_target = rsp_data;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R7
  branch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> (!dst_we && !align_err && done));

  // R5
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_kind != 3'd0) |-> (!wb_we && !dst_we && !br_valid && !hazard));

  // R6
  hazard_ports_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> (wb_we && dst_we && wb_idx == dst_idx));

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, busy}) && (in_ready || busy));
endmodule

// File: tb/ldx_unit_tb_top.sv
module ldx_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_compact, in_it_inside, in_it_last;
  logic        in_ready;
  logic [31:0] in_instr;
  logic [3:0]  base_ridx;
  logic [31:0] base_rdata;
  logic        req_valid, req_ready, rsp_valid;
  logic [31:0] req_addr, rsp_data;
  logic        busy, done, hazard, align_err, wb_we, dst_we, br_valid;
  logic [2:0]  done_kind;
  logic [3:0]  wb_idx, dst_idx;
  logic [31:0] wb_data, dst_data, br_target;

  always #5 clk = ~clk;

  logic [31:0] regs [16];
  assign base_rdata = regs[base_ridx];

  ldx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_compact(in_compact), .in_it_inside(in_it_inside),
    .in_it_last(in_it_last), .base_ridx(base_ridx), .base_rdata(base_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .done(done),
    .done_kind(done_kind), .hazard(hazard), .align_err(align_err),
    .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data), .dst_we(dst_we),
    .dst_idx(dst_idx), .dst_data(dst_data), .br_valid(br_valid), .br_target(br_target)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    string       tag;
    logic [2:0]  kind;
    logic        has_req;
    logic [31:0] addr;
    logic        hz, ae, wbe, dse, br;
    logic [3:0]  wbi, dsi;
    logic [31:0] wbd, dsd, bt;
  } exp_t;
  exp_t sb[$];

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {a[7:0], a[15:8], ~a[23:16], a[31:24]} ^ 32'h1357_9BDF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic drive(input logic [31:0] ins, input logic cmp, input logic iti, input logic itl);
    in_valid = 1'b1; in_instr = ins; in_compact = cmp; in_it_inside = iti; in_it_last = itl;
    @(negedge clk);
    in_valid = 1'b0; in_it_inside = 1'b0; in_it_last = 1'b0;
  endtask

  task automatic go_exec(input logic [31:0] ins, input logic cmp, input logic iti, input logic itl,
                         input logic [3:0] rn, input logic [3:0] rt, input logic [31:0] imm,
                         input logic idx, input logic add, input logic wb, input string tag);
    exp_t e;
    logic [31:0] base, offs;
    wait_ready();
    base = regs[rn];
    offs = add ? base + imm : base - imm;
    e.tag = tag; e.kind = 3'd0; e.has_req = 1'b1;
    e.addr = idx ? offs : base;
    e.hz  = wb && (rn == rt);
    e.ae  = (rt == 4'd15) && (e.addr[1:0] != 2'b00);
    e.br  = (rt == 4'd15) && (e.addr[1:0] == 2'b00);
    e.wbe = wb; e.wbi = rn; e.wbd = offs;
    e.dse = (rt != 4'd15); e.dsi = rt; e.dsd = mem_word(e.addr);
    e.bt  = mem_word(e.addr);
    sb.push_back(e);
    drive(ins, cmp, iti, itl);
  endtask

  task automatic go_rej(input logic [31:0] ins, input logic cmp, input logic iti, input logic itl,
                        input logic [2:0] kind, input string tag);
    exp_t e;
    wait_ready();
    e.tag = tag; e.kind = kind; e.has_req = 1'b0; e.addr = '0;
    e.hz = 0; e.ae = 0; e.br = 0; e.wbe = 0; e.dse = 0;
    e.wbi = '0; e.dsi = '0; e.wbd = '0; e.dsd = '0; e.bt = '0;
    sb.push_back(e);
    drive(ins, cmp, iti, itl);
  endtask

  function automatic logic [31:0] enc_fix(logic [3:0] c, logic p, logic u, logic w,
                                          logic [3:0] rn, logic [3:0] rt, logic [11:0] im);
    return {c, 3'b010, p, u, 1'b0, w, 1'b1, rn, rt, im};
  endfunction
  function automatic logic [31:0] enc_s5(logic [4:0] im, logic [2:0] rn, logic [2:0] rt);
    return {5'b01101, im, rn, rt, 16'h0000};
  endfunction
  function automatic logic [31:0] enc_sp(logic [2:0] rt, logic [7:0] im);
    return {5'b10011, rt, im, 16'h0000};
  endfunction
  function automatic logic [31:0] enc_w12(logic [3:0] rn, logic [3:0] rt, logic [11:0] im);
    return {12'hF8D, rn, rt, im};
  endfunction
  function automatic logic [31:0] enc_w8(logic [3:0] rn, logic [3:0] rt, logic p, logic u, logic w, logic [7:0] im);
    return {12'hF85, rn, rt, 1'b1, p, u, w, im};
  endfunction

  // memory model with varying stalls
  int nreq = 0;
  initial begin
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    forever begin
      logic [31:0] a;
      @(negedge clk);
      rsp_valid = 1'b0;
      if (req_valid) begin
        repeat (nreq % 3) @(negedge clk);
        req_ready = 1'b1; a = req_addr;
        @(negedge clk);
        req_ready = 1'b0;
        repeat ((nreq / 3) % 3) @(negedge clk);
        rsp_valid = 1'b1; rsp_data = mem_word(a);
        nreq++;
      end
    end
  end

  // monitor / scoreboard
  int          seen_req = 0;
  logic [31:0] seen_addr = '0;
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && req_valid && req_ready) begin
        seen_req++; seen_addr = req_addr;
        chk(busy && !in_ready, "R9 busy during request", {busy, in_ready}, 2'b10);
      end
      if (rst_n && done) begin
        if (sb.size() == 0) chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(done_kind == e.kind, {e.tag, " kind"}, done_kind, e.kind);
          chk(seen_req == int'(e.has_req), {e.tag, " request count"}, seen_req, e.has_req);
          if (e.has_req) chk(seen_addr == e.addr, {e.tag, " address"}, seen_addr, e.addr);
          chk(hazard == e.hz && align_err == e.ae, {e.tag, " flags"}, {hazard, align_err}, {e.hz, e.ae});
          chk(wb_we == e.wbe && (!e.wbe || (wb_idx == e.wbi && wb_data == e.wbd)),
              {e.tag, " base writeback"}, wb_data, e.wbd);
          chk(dst_we == e.dse && (!e.dse || (dst_idx == e.dsi && dst_data == e.dsd)),
              {e.tag, " destination"}, dst_data, e.dsd);
          chk(br_valid == e.br && (!e.br || br_target == e.bt), {e.tag, " branch"}, br_target, e.bt);
        end
        if (wb_we)  regs[wb_idx]  = wb_data;
        if (dst_we) regs[dst_idx] = dst_data;
        seen_req = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", sb.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 + 32'h100 * i;
    regs[11] = 32'h4000_0002;
    regs[12] = 32'h5000_0000;
    regs[13] = 32'h2000_0400;
    in_valid = 0; in_instr = '0; in_compact = 0; in_it_inside = 0; in_it_last = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(in_ready && !busy && !req_valid && !done, "R10 reset outputs", {in_ready, busy, req_valid, done}, 4'b1000);
    chk(!wb_we && !dst_we && !br_valid, "R10 reset strobes", {wb_we, dst_we, br_valid}, 3'b000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R4 fixed form, pre-index add, no writeback
    go_exec(enc_fix(4'hE, 1, 1, 0, 4'd1, 4'd2, 12'h024), 0, 0, 0, 1, 2, 32'h24, 1, 1, 0, "R1 pre-add");
    // R4 pre-index subtract with writeback
    go_exec(enc_fix(4'h0, 1, 0, 1, 4'd3, 4'd4, 12'h010), 0, 0, 0, 3, 4, 32'h10, 1, 0, 1, "R4 pre-sub-wb");
    // R4 post-index add
    go_exec(enc_fix(4'h1, 0, 1, 0, 4'd5, 4'd6, 12'h100), 0, 0, 0, 5, 6, 32'h100, 0, 1, 1, "R4 post-add");
    // R4 post-index subtract, max immediate
    go_exec(enc_fix(4'hA, 0, 0, 0, 4'd7, 4'd8, 12'hFFF), 0, 0, 0, 7, 8, 32'hFFF, 0, 0, 1, "R4 post-sub-max");
    // R11 stack pop pattern
    go_exec(enc_fix(4'hE, 0, 1, 0, 4'd13, 4'd9, 12'h004), 0, 0, 0, 13, 9, 32'h4, 0, 1, 1, "R11 pop");
    // R5 refusals in fixed form
    go_rej(enc_fix(4'hE, 0, 1, 1, 4'd1, 4'd2, 12'h0), 0, 0, 0, 3'd2, "R5 fixed unpriv");
    go_rej(enc_fix(4'hE, 1, 1, 0, 4'd15, 4'd2, 12'h8), 0, 0, 0, 3'd1, "R5 fixed literal");
    go_rej(enc_fix(4'hF, 1, 1, 0, 4'd1, 4'd2, 12'h8), 0, 0, 0, 3'd4, "R5 fixed cond all-ones");
    // R6 hazard
    go_exec(enc_fix(4'hE, 1, 1, 1, 4'd4, 4'd4, 12'h020), 0, 0, 0, 4, 4, 32'h20, 1, 1, 1, "R6 hazard");
    // R7 PC destination aligned and unaligned
    go_exec(enc_fix(4'hE, 1, 1, 0, 4'd11, 4'd15, 12'h002), 0, 0, 0, 11, 15, 32'h2, 1, 1, 0, "R7 pc aligned");
    go_exec(enc_fix(4'hE, 1, 1, 0, 4'd11, 4'd15, 12'h001), 0, 0, 0, 11, 15, 32'h1, 1, 1, 0, "R7 pc unaligned");
    // R2 short forms
    go_exec(enc_s5(5'd5, 3'd2, 3'd3), 1, 0, 0, 2, 3, 32'h14, 1, 1, 0, "R2 imm5");
    go_exec(enc_s5(5'd31, 3'd7, 3'd0), 1, 0, 0, 7, 0, 32'h7C, 1, 1, 0, "R2 imm5 max");
    go_exec(enc_sp(3'd5, 8'h33), 1, 0, 0, 13, 5, 32'hCC, 1, 1, 0, "R2 sp-relative");
    // R3 wide forms
    go_exec(enc_w12(4'd6, 4'd7, 12'h7FC), 1, 0, 0, 6, 7, 32'h7FC, 1, 1, 0, "R3 imm12");
    go_exec(enc_w8(4'd8, 4'd9, 1, 0, 1, 8'h20), 1, 0, 0, 8, 9, 32'h20, 1, 0, 1, "R3 imm8 pre-sub-wb");
    go_exec(enc_w8(4'd13, 4'd10, 0, 1, 1, 8'h04), 1, 0, 0, 13, 10, 32'h4, 0, 1, 1, "R11 R3 wide pop");
    go_rej(enc_w12(4'd15, 4'd1, 12'h10), 1, 0, 0, 3'd1, "R5 wide literal");
    go_rej(enc_w8(4'd1, 4'd2, 1, 1, 0, 8'h4), 1, 0, 0, 3'd2, "R5 wide unpriv");
    go_rej(enc_w8(4'd1, 4'd2, 0, 1, 0, 8'h4), 1, 0, 0, 3'd3, "R5 wide undef");
    go_rej(32'h4600_0000, 1, 0, 0, 3'd4, "R5 compact foreign");
    go_rej({12'hF85, 4'd1, 4'd2, 1'b0, 3'b110, 8'h4}, 1, 0, 0, 3'd4, "R5 imm8 bit11 clear");
    // R8 conditional group with PC destination
    go_rej(enc_w12(4'd12, 4'd15, 12'h010), 1, 1, 0, 3'd5, "R8 imm12 pc mid-group");
    go_rej(enc_w8(4'd12, 4'd15, 1, 1, 1, 8'h10), 1, 1, 0, 3'd5, "R8 imm8 pc mid-group");
    go_exec(enc_w12(4'd12, 4'd15, 12'h010), 1, 1, 1, 12, 15, 32'h10, 1, 1, 0, "R8 pc last-in-group");
    go_exec(enc_w12(4'd12, 4'd1, 12'h010), 1, 1, 0, 12, 1, 32'h10, 1, 1, 0, "R8 non-pc mid-group");

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule